// File: doc/BRIEF.md
# Transmit Mailbox Status Tracker

This block holds the status of the three transmit mailboxes of a frame controller and presents it as one 32-bit status word. A transmit engine sends it single-cycle event pulses per mailbox: attempt start, good completion, error completion, lost arbitration and abort. Software fills a mailbox by pulsing its request enable, asks for a transmission to stop through a stop write, and clears flags by writing ones to the status word.

Each mailbox keeps a finished flag, a success flag, an arbitration-lost flag, an error flag, a stop-request flag and an empty flag. A 2-bit slot index tells software where to put the next frame. When every mailbox is full, the index instead names the mailbox whose frame will go out last, which is the one filled most recently.

Top module: `tx_mbox_status`

## Requirements
- R1: After reset the status word reads 0x1C00_0000: all three empty flags set, the index at 0, every other bit 0.
- R2: Empty flag of mailbox m sits at bit 26+m. A fill pulse clears it. A good completion, an error completion or an abort of that mailbox sets it.
- R3: While at least one mailbox is empty, the index at bits 25:24 holds the lowest-numbered empty mailbox.
- R4: While all three are full, the index holds the mailbox filled most recently. When several fill in one cycle, the highest-numbered of them counts as most recent.
- R5: Stop flag (byte bit 7) is set by a stop write that selects the mailbox. It is held at 0 whenever that mailbox is empty.
- R6: Error flag (byte bit 3) is set by an error completion. It is cleared by a new attempt start, or by a software write of 1 to byte bit 3 or to byte bit 0.
- R7: Arbitration-lost flag (byte bit 2) is set by a lost-arbitration pulse. It is cleared by a new attempt start, or by a write of 1 to byte bit 2 or byte bit 0.
- R8: Success flag (byte bit 1) is set by a good completion. It is cleared by an error completion, or by a write of 1 to byte bit 1 or byte bit 0.
- R9: Finished flag (byte bit 0) is set by a good completion, an error completion or an abort. It is cleared by a write of 1 to byte bit 0 or by a fill pulse.
- R10: When a hardware set and a software clear reach the same flag in one cycle, the flag ends up set.
- R11: Byte bits 6:4 and status bits 31:29 always read 0. Writing 1 there, writing 0 anywhere, and any write with the clear strobe low have no effect. Mailbox m occupies bits 8m+7:8m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| eng_start | input | 3 | Per-mailbox pulse: transmission attempt begins |
| eng_ok | input | 3 | Per-mailbox pulse: transmission completed without error |
| eng_err | input | 3 | Per-mailbox pulse: transmission completed with error |
| eng_arb_lost | input | 3 | Per-mailbox pulse: arbitration lost |
| eng_abort | input | 3 | Per-mailbox pulse: transmission aborted |
| fill_req | input | 3 | Per-mailbox pulse: software set the request enable (mailbox filled) |
| sw_clr_we | input | 1 | Write strobe for write-one-to-clear of the status word |
| sw_clr_data | input | 32 | Write data; ones mark bits to clear |
| sw_stop_we | input | 1 | Write strobe for stop requests |
| sw_stop_sel | input | 3 | Mailboxes receiving a stop request |
| status | output | 32 | Packed status word |

## Verification
The assertions take for granted that the engine sends at most one event per mailbox in a cycle, only to a mailbox that is full, and that fill pulses reach only empty mailboxes. Under those rules the empty flag, the stop flag and the index stay consistent with each other. The random stimulus reads the bench's own model of the empty flags before it drives anything, so it keeps to these rules. Software writes and stop requests are left unconstrained, because the block must accept them in any cycle.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
  typedef struct packed {
    logic stop;
    logic err;
    logic arb;
    logic succ;
    logic fin;
  } mb_flags_t;

  localparam int unsigned BYTE_W = 8;

  // Byte image of one mailbox: stop at 7, reserved 6:4, err/arb/succ/fin at 3:0
  function automatic logic [BYTE_W-1:0] flags_to_byte(mb_flags_t f);
    return {f.stop, 3'b000, f.err, f.arb, f.succ, f.fin};
  endfunction
endpackage

// File: rtl/txmb_slot.sv
module txmb_slot
  import txmb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_ok,
  input  logic       ev_err,
  input  logic       ev_arb,
  input  logic       ev_abort,
  input  logic       fill,
  input  logic [3:0] w1c,
  input  logic       stop_req,
  output mb_flags_t  flags,
  output logic       empty
);
  mb_flags_t flags_q, flags_d;
  logic      empty_q, empty_d;
  logic      hw_done, ce;

  always_comb begin
    hw_done = ev_ok | ev_err | ev_abort;
    flags_d = flags_q;
    empty_d = empty_q;

    if (hw_done)                    flags_d.fin  = 1'b1;
    else if (w1c[0] || fill)        flags_d.fin  = 1'b0;

    if (ev_ok)                      flags_d.succ = 1'b1;
    else if (ev_err || w1c[1] || w1c[0]) flags_d.succ = 1'b0;

    if (ev_arb)                     flags_d.arb  = 1'b1;
    else if (ev_start || w1c[2] || w1c[0]) flags_d.arb = 1'b0;

    if (ev_err)                     flags_d.err  = 1'b1;
    else if (ev_start || w1c[3] || w1c[0]) flags_d.err = 1'b0;

    if (fill)                       empty_d = 1'b0;
    else if (hw_done)               empty_d = 1'b1;

    flags_d.stop = (flags_q.stop | stop_req) & ~empty_d;

    ce = ev_start | hw_done | ev_arb | fill | (|w1c) | stop_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      empty_q <= 1'b1;
    end else if (ce) begin
      flags_q <= flags_d;
      empty_q <= empty_d;
    end
  end

  assign flags = flags_q;
  assign empty = empty_q;
endmodule

// File: rtl/txmb_pick.sv
module txmb_pick #(
  parameter int unsigned N_MBOX = 3,
  localparam int unsigned IDX_W = (N_MBOX > 1) ? $clog2(N_MBOX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MBOX-1:0] empty,
  input  logic [N_MBOX-1:0] fill,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0] last_q, last_d;
  logic [IDX_W-1:0] low_empty;
  logic             any_empty;

  always_comb begin
    last_d = last_q;
    for (int i = 0; i < int'(N_MBOX); i++) begin
      if (fill[i]) last_d = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_q <= '0;
    else if (|fill)  last_q <= last_d;
  end

  always_comb begin
    low_empty = '0;
    any_empty = 1'b0;
    for (int i = int'(N_MBOX) - 1; i >= 0; i--) begin
      if (empty[i]) begin
        low_empty = IDX_W'(i);
        any_empty = 1'b1;
      end
    end
    idx = any_empty ? low_empty : last_q;
  end
endmodule

// File: rtl/tx_mbox_status.sv
module tx_mbox_status
  import txmb_pkg::*;
#(
  parameter int unsigned N_MBOX    = 3,
  parameter int unsigned STAT_W    = 32,
  parameter int unsigned IDX_LSB   = 24,
  parameter int unsigned EMPTY_LSB = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MBOX-1:0] eng_start,
  input  logic [N_MBOX-1:0] eng_ok,
  input  logic [N_MBOX-1:0] eng_err,
  input  logic [N_MBOX-1:0] eng_arb_lost,
  input  logic [N_MBOX-1:0] eng_abort,
  input  logic [N_MBOX-1:0] fill_req,
  input  logic              sw_clr_we,
  input  logic [STAT_W-1:0] sw_clr_data,
  input  logic              sw_stop_we,
  input  logic [N_MBOX-1:0] sw_stop_sel,
  output logic [STAT_W-1:0] status
);
  localparam int unsigned IDX_W = (N_MBOX > 1) ? $clog2(N_MBOX) : 1;

  mb_flags_t         flags [N_MBOX];
  logic [N_MBOX-1:0] empty;
  logic [IDX_W-1:0]  idx;

  for (genvar m = 0; m < N_MBOX; m++) begin : g_slot
    logic [3:0] w1c_m;
    assign w1c_m = sw_clr_we ? sw_clr_data[m*BYTE_W +: 4] : 4'b0000;

    txmb_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_start (eng_start[m]),
      .ev_ok    (eng_ok[m]),
      .ev_err   (eng_err[m]),
      .ev_arb   (eng_arb_lost[m]),
      .ev_abort (eng_abort[m]),
      .fill     (fill_req[m]),
      .w1c      (w1c_m),
      .stop_req (sw_stop_we & sw_stop_sel[m]),
      .flags    (flags[m]),
      .empty    (empty[m])
    );
  end

  txmb_pick #(.N_MBOX(N_MBOX)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .empty (empty),
    .fill  (fill_req),
    .idx   (idx)
  );

  always_comb begin
    status = '0;
    for (int m = 0; m < int'(N_MBOX); m++) begin
      status[m*BYTE_W +: BYTE_W] = flags_to_byte(flags[m]);
    end
    status[IDX_LSB +: IDX_W]    = idx;
    status[EMPTY_LSB +: N_MBOX] = empty;
  end
endmodule

// File: rtl/txmb_status_chk.sv
module txmb_status_chk #(
  parameter int unsigned N_MBOX    = 3,
  parameter int unsigned STAT_W    = 32,
  parameter int unsigned IDX_LSB   = 24,
  parameter int unsigned EMPTY_LSB = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_MBOX-1:0] eng_start,
  input logic [N_MBOX-1:0] eng_ok,
  input logic [N_MBOX-1:0] eng_err,
  input logic [N_MBOX-1:0] eng_arb_lost,
  input logic [N_MBOX-1:0] eng_abort,
  input logic [N_MBOX-1:0] fill_req,
  input logic              sw_clr_we,
  input logic [STAT_W-1:0] sw_clr_data,
  input logic              sw_stop_we,
  input logic [N_MBOX-1:0] sw_stop_sel,
  input logic [STAT_W-1:0] status
);
  localparam int unsigned IDX_W = (N_MBOX > 1) ? $clog2(N_MBOX) : 1;

  logic [N_MBOX:0]  empty_ext;
  logic [IDX_W-1:0] idx;
  logic [N_MBOX:0]  below_mask;

  assign empty_ext  = {1'b0, status[EMPTY_LSB +: N_MBOX]};
  assign idx        = status[IDX_LSB +: IDX_W];
  assign below_mask = ((N_MBOX+1)'(1) << idx) - (N_MBOX+1)'(1);

  // R3: index names the lowest empty mailbox while any is empty
  a_r3_lowest_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_ext != '0) |-> (empty_ext[idx] && ((empty_ext & below_mask) == '0)));

  // R11: top reserved bits stay 0
  a_r11_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[STAT_W-1:EMPTY_LSB+N_MBOX] == '0);

  for (genvar m = 0; m < N_MBOX; m++) begin : g_mb
    a_r2_fill_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req[m] |=> !status[EMPTY_LSB+m]);

    a_r9_fin_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_ok[m] || eng_err[m] || eng_abort[m]) |=> status[m*8]);

    a_r6_start_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start[m] && !eng_err[m]) |=> !status[m*8+3]);

    a_r10_err_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_err[m] && sw_clr_we && sw_clr_data[m*8+3]) |=> status[m*8+3]);

    a_r5_no_stop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      status[EMPTY_LSB+m] |-> !status[m*8+7]);

    a_r11_byte_resv_zero: assert property (@(posedge clk) disable iff (!rst_n)
      status[m*8+4 +: 3] == 3'b000);
  end
endmodule

bind tx_mbox_status txmb_status_chk #(
  .N_MBOX(N_MBOX), .STAT_W(STAT_W), .IDX_LSB(IDX_LSB), .EMPTY_LSB(EMPTY_LSB)
) u_chk (.*);

// File: tb/tb_tx_mbox_status.sv
module tb_tx_mbox_status;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  eng_start, eng_ok, eng_err, eng_arb_lost, eng_abort, fill_req;
  logic        sw_clr_we, sw_stop_we;
  logic [31:0] sw_clr_data;
  logic [2:0]  sw_stop_sel;
  logic [31:0] status;

  int checks = 0;
  int fails  = 0;

  // Behavioural reference state
  bit m_fin[3], m_succ[3], m_arb[3], m_err[3], m_stop[3], m_emp[3];
  int m_last;

  always #4 clk = ~clk;

  tx_mbox_status dut (
    .clk(clk), .rst_n(rst_n),
    .eng_start(eng_start), .eng_ok(eng_ok), .eng_err(eng_err),
    .eng_arb_lost(eng_arb_lost), .eng_abort(eng_abort), .fill_req(fill_req),
    .sw_clr_we(sw_clr_we), .sw_clr_data(sw_clr_data),
    .sw_stop_we(sw_stop_we), .sw_stop_sel(sw_stop_sel),
    .status(status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    eng_start = '0; eng_ok = '0; eng_err = '0; eng_arb_lost = '0;
    eng_abort = '0; fill_req = '0; sw_clr_we = 1'b0; sw_clr_data = '0;
    sw_stop_we = 1'b0; sw_stop_sel = '0;
  endtask

  task automatic model_reset();
    for (int m = 0; m < 3; m++) begin
      m_fin[m] = 0; m_succ[m] = 0; m_arb[m] = 0; m_err[m] = 0;
      m_stop[m] = 0; m_emp[m] = 1;
    end
    m_last = 0;
  endtask

  task automatic model_step();
    for (int m = 0; m < 3; m++) begin
      bit [3:0] w;
      bit ended;
      w = sw_clr_we ? sw_clr_data[m*8 +: 4] : 4'b0;
      ended = eng_ok[m] || eng_err[m] || eng_abort[m];
      if (ended) m_fin[m] = 1; else if (w[0] || fill_req[m]) m_fin[m] = 0;
      if (eng_ok[m]) m_succ[m] = 1; else if (eng_err[m] || w[1] || w[0]) m_succ[m] = 0;
      if (eng_arb_lost[m]) m_arb[m] = 1; else if (eng_start[m] || w[2] || w[0]) m_arb[m] = 0;
      if (eng_err[m]) m_err[m] = 1; else if (eng_start[m] || w[3] || w[0]) m_err[m] = 0;
      if (fill_req[m]) m_emp[m] = 0; else if (ended) m_emp[m] = 1;
      m_stop[m] = (m_stop[m] || (sw_stop_we && sw_stop_sel[m])) && !m_emp[m];
      if (fill_req[m]) m_last = m;
    end
  endtask

  task automatic compare_all();
    int exp_idx;
    bit any_empty;
    any_empty = m_emp[0] || m_emp[1] || m_emp[2];
    for (int m = 0; m < 3; m++) begin
      chk("R9 finished",   int'(status[m*8]),     int'(m_fin[m]));
      chk("R8 success",    int'(status[m*8+1]),   int'(m_succ[m]));
      chk("R7 arb-lost",   int'(status[m*8+2]),   int'(m_arb[m]));
      chk("R6 error",      int'(status[m*8+3]),   int'(m_err[m]));
      chk("R11 reserved",  int'(status[m*8+4 +: 3]), 0);
      chk("R5 stop",       int'(status[m*8+7]),   int'(m_stop[m]));
      chk("R2 empty",      int'(status[26+m]),    int'(m_emp[m]));
    end
    chk("R11 top bits", int'(status[31:29]), 0);
    if (any_empty) begin
      exp_idx = m_emp[0] ? 0 : (m_emp[1] ? 1 : 2);
      chk("R3 index lowest empty", int'(status[25:24]), exp_idx);
    end else begin
      chk("R4 index last queued", int'(status[25:24]), m_last);
    end
  endtask

  // Inputs are set at a negedge, the model advances, the design clocks at the
  // next posedge and the result is sampled at the following negedge.
  task automatic step();
    model_step();
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic rand_cycle();
    for (int m = 0; m < 3; m++) begin
      int r;
      r = int'($urandom % 10);
      if (m_emp[m]) begin
        if (r < 4) fill_req[m] = 1'b1;
      end else begin
        case (r)
          0, 1: eng_start[m]    = 1'b1;
          2:    eng_ok[m]       = 1'b1;
          3:    eng_err[m]      = 1'b1;
          4:    eng_arb_lost[m] = 1'b1;
          5:    eng_abort[m]    = 1'b1;
          default: ;
        endcase
      end
    end
    if ($urandom % 4 == 0) begin
      sw_clr_we   = 1'b1;
      sw_clr_data = $urandom;
    end else if ($urandom % 6 == 0) begin
      sw_clr_data = $urandom;  // data without strobe must do nothing (R11)
    end
    if ($urandom % 3 == 0) begin
      sw_stop_we  = 1'b1;
      sw_stop_sel = 3'($urandom);
    end
  endtask

  bit finished = 0;

  initial begin
    idle_inputs();
    model_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset word", int'(status), 32'h1C00_0000);
    compare_all();

    // R4: fill 0, then 2, then 1; all full, last queued is mailbox 1
    fill_req = 3'b001; step();
    fill_req = 3'b100; step();
    fill_req = 3'b010; step();
    chk("R4 all full index", int'(status[25:24]), 1);

    // R5: stop set on full mailbox 2, dropped when it empties by abort
    sw_stop_we = 1'b1; sw_stop_sel = 3'b100; step();
    chk("R5 stop set", int'(status[23]), 1);
    eng_abort[2] = 1'b1; step();
    chk("R5 stop cleared when empty", int'(status[23]), 0);
    chk("R3 index after abort", int'(status[25:24]), 2);

    // R10: error completion and full-byte clear in the same cycle on mailbox 0
    eng_err[0] = 1'b1; sw_clr_we = 1'b1; sw_clr_data = 32'h0000_00FF; step();
    chk("R10 error survives clear", int'(status[3]), 1);
    chk("R10 finished survives clear", int'(status[0]), 1);

    // R6: clearing finished flag clears error as well
    sw_clr_we = 1'b1; sw_clr_data = 32'h0000_0001; step();
    chk("R6 error cleared via finished", int'(status[3]), 0);

    // R11: ones to reserved bits and zero writes change nothing
    sw_clr_we = 1'b1; sw_clr_data = 32'hE0F0_7070; step();
    sw_clr_we = 1'b1; sw_clr_data = 32'h0; step();

    for (int n = 0; n < 4000; n++) begin
      rand_cycle();
      step();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule